// File: doc/BRIEF.md
# Bidirectional Overcurrent Detector with Blanking

This block watches the switch-node current of a half bridge during the interval in which the low-side switch conducts. Two digital comparator results come in from outside. One says the node sits above the positive trip level and the other says it sits below the negative trip level. The block also receives the low-side enable that the gate logic drives. After each low-side turn-on, a fixed leading-edge blanking window hides the switching ringing. Once that window has passed, a trip in either direction that lasts for a set number of consecutive samples drives an active-low fault output.

The fault output stays asserted for as long as the qualified trip lasts. After the trip clears, it is stretched to a minimum width so that a slow processor can still read it. A power-good input marks the interval in which the supply is valid. While power-good is low, the fault output is held inactive and all internal state is cleared. The comparator inputs are treated as asynchronous and are synchronised. The low-side enable is taken to be synchronous to the clock.

Top module: `bidir_oc_detect`

## Requirements
- R1: While rstN is low, faultN is 1 (inactive) and all internal state is cleared.
- R2: The comparator inputs are evaluated only on clock edges where lowOn is 1. With lowOn held at 0, no comparator activity brings faultN to 0.
- R3: Comparator samples are ignored during the first BLANK_CYC edges that sample lowOn high in each low-side on interval. The window restarts after any edge that samples lowOn low.
- R4: A low-side on interval of BLANK_CYC edges or fewer never produces a fault, whatever the comparators do.
- R5: Either overHi or underLo qualifies as a trip. Both are ORed into one fault condition.
- R6: Each comparator input passes through a two-flop synchroniser. Suppose the window is open and the trip reaches the required count of samples. The first synchronised sample is taken two edges after the raw input is applied, and faultN then goes to 0 right after the QUAL_CNT-th consecutive open sample.
- R7: A trip seen for fewer than QUAL_CNT consecutive open samples is rejected and leaves faultN at 1.
- R8: faultN is 0 (0 means overcurrent, 1 means no fault) on every cycle in which a qualified trip persists.
- R9: After a qualified trip ends, faultN stays 0 for MIN_PULSE further cycles. This holds also when the trip ends because lowOn fell.
- R10: While pwrGood is 0, faultN is 1 in the same cycle and all counters and synchroniser stages are cleared. Blanking and qualification start again from zero once pwrGood returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (100 MHz nominal sizing) |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply valid; low forces the fault output inactive and clears state |
| lowOn | input | 1 | Low-side switch enable, synchronous to clk |
| overHi | input | 1 | Asynchronous comparator: node above positive trip level |
| underLo | input | 1 | Asynchronous comparator: node below negative trip level |
| faultN | output | 1 | Active-low overcurrent flag, stretched to a minimum width |

## Verification
Two functions can act in the same cycle. Ending the evaluation window when lowOn falls can coincide with the start of the pulse stretch, and removing power-good can coincide with an active or stretched fault. The bench provokes the first case by dropping lowOn while a qualified trip is still present. It provokes the second case by pulling pwrGood low in the middle of a stretched pulse. Every cycle is compared against a reference model that is built from the requirements. Explicit checks confirm that faultN is released at once when power-good falls, and that it stays low for at least the minimum width after the turn-off.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic evalOpen;   // sampling window open: low side on and blanking expired
    logic clrAll;     // supply not valid: clear all state, force output inactive
  } ctlStrb_t;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl import oc_pkg::*; #(
  parameter int BLANK_CYC = 20
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrGood,
  input  logic     lowOn,
  output ctlStrb_t strb
);
  localparam int BW = $clog2(BLANK_CYC + 1) + 1;
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic [BW-1:0] blankCnt;

  // Counts edges with the low side on; any low sample restarts the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   blankCnt <= '0;
    else if (!pwrGood || !lowOn) blankCnt <= '0;
    else if (blankCnt != BLANK_END) blankCnt <= blankCnt + 1'b1;
  end

  assign strb.evalOpen = pwrGood && lowOn && (blankCnt == BLANK_END);
  assign strb.clrAll   = !pwrGood;
endmodule

// File: rtl/oc_dpath.sv
module oc_dpath import oc_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CNT    = 2,
  parameter int MIN_PULSE   = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctlStrb_t strb,
  input  logic     overHi,
  input  logic     underLo,
  output logic     faultN
);
  localparam int NCH = 2;
  localparam int QW  = $clog2(QUAL_CNT + 1) + 1;
  localparam int SW  = $clog2(MIN_PULSE + 1) + 1;
  localparam logic [QW-1:0] QUAL_END  = QW'(QUAL_CNT);
  localparam logic [SW-1:0] PULSE_LEN = SW'(MIN_PULSE);

  logic [NCH-1:0] rawTrip, tripSync;
  assign rawTrip = {underLo, overHi};

  for (genvar ch = 0; ch < NCH; ch++) begin : gSync
    logic [SYNC_STAGES-1:0] syncReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            syncReg <= '0;
      else if (strb.clrAll) syncReg <= '0;
      else                  syncReg <= {syncReg[SYNC_STAGES-2:0], rawTrip[ch]};
    end
    assign tripSync[ch] = syncReg[SYNC_STAGES-1];
  end

  logic          tripAny;
  logic [QW-1:0] qualCnt;
  logic [SW-1:0] stretchCnt;
  logic          qualified;

  assign tripAny   = |tripSync;
  assign qualified = (qualCnt == QUAL_END);

  // Consecutive open-window trip samples, saturating at the qualify count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          qualCnt <= '0;
    else if (strb.clrAll || !(strb.evalOpen && tripAny)) qualCnt <= '0;
    else if (!qualified)                                qualCnt <= qualCnt + 1'b1;
  end

  // One-shot stretch, reloaded on every qualified cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stretchCnt <= '0;
    else if (strb.clrAll)       stretchCnt <= '0;
    else if (qualified)         stretchCnt <= PULSE_LEN;
    else if (stretchCnt != '0)  stretchCnt <= stretchCnt - 1'b1;
  end

  assign faultN = strb.clrAll || !(qualified || (stretchCnt != '0));
endmodule

// File: rtl/bidir_oc_detect.sv
module bidir_oc_detect import oc_pkg::*; #(
  parameter int BLANK_CYC   = 20,
  parameter int QUAL_CNT    = 2,
  parameter int MIN_PULSE   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic lowOn,
  input  logic overHi,
  input  logic underLo,
  output logic faultN
);
  ctlStrb_t strb;

  oc_ctrl #(.BLANK_CYC(BLANK_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .lowOn(lowOn), .strb(strb)
  );

  oc_dpath #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CNT(QUAL_CNT), .MIN_PULSE(MIN_PULSE)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .overHi(overHi), .underLo(underLo), .faultN(faultN)
  );
endmodule

// File: rtl/bidir_oc_detect_chk.sv
module bidir_oc_detect_chk #(
  parameter int BLANK_CYC = 20,
  parameter int QUAL_CNT  = 2,
  parameter int MIN_PULSE = 10
) (
  input logic clk,
  input logic rstN,
  input logic pwrGood,
  input logic lowOn,
  input logic overHi,
  input logic underLo,
  input logic faultN
);
  localparam int RUN_LIM = BLANK_CYC + QUAL_CNT;
  localparam int RW = $clog2(RUN_LIM + 1) + 1;
  localparam int LW = $clog2(MIN_PULSE + 1) + 1;

  logic [RW-1:0] runCnt;
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   runCnt <= '0;
    else if (!pwrGood || !lowOn) runCnt <= '0;
    else if (runCnt != RW'(RUN_LIM)) runCnt <= runCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (faultN)  lowCnt <= '0;
    else if (lowCnt != LW'(MIN_PULSE)) lowCnt <= lowCnt + 1'b1;
  end

  always @(posedge clk)
    if (!rstN) assert_reset_idle_R1: assert (faultN) else $error("faultN low in reset");

  assert_eval_needs_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> $past(lowOn)) else $error("fault raised without low side on");

  // Covers R3 and R4: a fault needs blanking plus qualification inside one on interval.
  assert_blank_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> (runCnt >= RW'(RUN_LIM))) else $error("fault inside blanking window");

  assert_min_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(faultN) && pwrGood) |-> (lowCnt >= LW'(MIN_PULSE))) else $error("fault pulse too short");

  assert_pg_forces_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |-> faultN) else $error("fault active without power good");
endmodule

bind bidir_oc_detect bidir_oc_detect_chk #(
  .BLANK_CYC(BLANK_CYC), .QUAL_CNT(QUAL_CNT), .MIN_PULSE(MIN_PULSE)
) uChk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .lowOn(lowOn),
  .overHi(overHi), .underLo(underLo), .faultN(faultN)
);

// File: tb/bidir_oc_detect_test.sv
module bidir_oc_detect_test;
  localparam int BLANK = 20;
  localparam int QUAL  = 2;
  localparam int MINW  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrGood = 1'b0, lowOn = 1'b0, overHi = 1'b0, underLo = 1'b0;
  logic faultN;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;
  string curReq = "R1";
  int lowSeen = 0;

  always #2 clk = ~clk;   // 250 MHz

  bidir_oc_detect #(.BLANK_CYC(BLANK), .QUAL_CNT(QUAL), .MIN_PULSE(MINW)) uut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .lowOn(lowOn),
    .overHi(overHi), .underLo(underLo), .faultN(faultN)
  );

  // Reference model built from the requirements.
  int mOnEdges = 0, mStreak = 0, mHold = 0;
  bit mRaw1 = 0, mRaw2 = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN || !pwrGood) begin
      mOnEdges = 0; mStreak = 0; mHold = 0; mRaw1 = 0; mRaw2 = 0;
    end else begin
      bit windowOpen, wasQual;
      windowOpen = lowOn && (mOnEdges >= BLANK);
      wasQual    = (mStreak >= QUAL);
      mStreak    = (windowOpen && mRaw2) ? ((mStreak + 1 > QUAL) ? QUAL : mStreak + 1) : 0;
      if (wasQual) mHold = MINW; else if (mHold > 0) mHold = mHold - 1;
      mOnEdges   = lowOn ? ((mOnEdges + 1 > BLANK) ? BLANK : mOnEdges + 1) : 0;
      mRaw2      = mRaw1;
      mRaw1      = overHi | underLo;
    end
  end

  function automatic bit expFaultN();
    return !pwrGood || !((mStreak >= QUAL) || (mHold > 0));
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    testsRun++;
    if (!cond) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(faultN === expFaultN(), curReq, int'(faultN), int'(expFaultN()));
    if (faultN === 1'b0) lowSeen++;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic idle(int n);
    lowOn = 0; overHi = 0; underLo = 0; ticks(n);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    // R1: reset state
    curReq = "R1";
    ticks(3);
    check(faultN === 1'b1, "R1", int'(faultN), 1);
    rstN = 1; pwrGood = 1;
    idle(4);

    // R5 / R6 / R8 / R9: positive direction trip
    curReq = "R5"; lowSeen = 0;
    lowOn = 1; ticks(22);
    overHi = 1; ticks(6);
    overHi = 0; ticks(16);
    check(lowSeen >= MINW + 1, "R5", lowSeen, MINW + 1);
    idle(6);

    // R5 / R9: negative direction trip, explicit width
    curReq = "R9"; lowSeen = 0;
    lowOn = 1; ticks(BLANK + 2);
    underLo = 1; ticks(QUAL + 2);
    underLo = 0; ticks(MINW + 6);
    check(lowSeen >= MINW, "R9", lowSeen, MINW);
    idle(6);

    // R6: latency from raw input to faultN
    curReq = "R6";
    lowOn = 1; ticks(BLANK + 4);
    overHi = 1; ticks(QUAL + 1);
    check(faultN === 1'b1, "R6", int'(faultN), 1);
    tick();
    check(faultN === 1'b0, "R6", int'(faultN), 0);
    overHi = 0; ticks(MINW + 4);
    idle(4);

    // R3 / R4: trip throughout a short on interval
    curReq = "R4"; lowSeen = 0;
    lowOn = 1; overHi = 1; ticks(BLANK);
    lowOn = 0; ticks(8);
    overHi = 0; ticks(4);
    check(lowSeen == 0, "R4", lowSeen, 0);

    // R3: window restarts after a one-cycle low
    curReq = "R3"; lowSeen = 0;
    lowOn = 1; ticks(BLANK + 5);
    lowOn = 0; ticks(1);
    lowOn = 1; underLo = 1; ticks(BLANK - 2);
    check(lowSeen == 0, "R3", lowSeen, 0);
    underLo = 0; idle(6);

    // R7: single-sample glitch after blanking
    curReq = "R7"; lowSeen = 0;
    lowOn = 1; ticks(BLANK + 4);
    overHi = 1; ticks(1);
    overHi = 0; ticks(10);
    check(lowSeen == 0, "R7", lowSeen, 0);
    idle(4);

    // R2: comparators active with low side off
    curReq = "R2"; lowSeen = 0;
    lowOn = 0; overHi = 1; underLo = 1; ticks(40);
    check(lowSeen == 0, "R2", lowSeen, 0);
    idle(4);

    // R9: turn-off while trip persists, stretch must survive
    curReq = "R9"; lowSeen = 0;
    lowOn = 1; ticks(BLANK + 2);
    overHi = 1; ticks(QUAL + 5);
    lowOn = 0; ticks(MINW);
    check(faultN === 1'b0, "R9", int'(faultN), 0);
    overHi = 0; ticks(6);
    check(faultN === 1'b1, "R9", int'(faultN), 1);

    // R10: power-good removed during a stretch
    curReq = "R10";
    lowOn = 1; ticks(BLANK + 2);
    underLo = 1; ticks(QUAL + 4);
    underLo = 0; lowOn = 0; ticks(2);
    pwrGood = 0; ticks(1);
    check(faultN === 1'b1, "R10", int'(faultN), 1);
    ticks(5);
    pwrGood = 1; lowOn = 1; underLo = 1; ticks(BLANK);
    check(faultN === 1'b1, "R10", int'(faultN), 1);
    underLo = 0; idle(14);

    // R8: constrained random mix
    curReq = "R8";
    for (int seg = 0; seg < 300; seg++) begin
      int len;
      lowOn   = $urandom_range(0, 2) != 0;
      pwrGood = $urandom_range(0, 29) != 0;
      len     = $urandom_range(1, 40);
      for (int i = 0; i < len; i++) begin
        overHi  = $urandom_range(0, 5) == 0;
        underLo = $urandom_range(0, 7) == 0;
        tick();
      end
    end
    pwrGood = 1; idle(20);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule